// File: doc/BRIEF.md
# Selectable Tone Generation Controller

This block produces the digital control for a 22 kHz signalling tone that a downstream wave-shaping stage adds on top of a regulated supply level. It takes a one-cycle enable pulse at 352 kHz from the system clock domain, an asynchronous external modulation pin and two control bits. The two bits are a source select and a gate. From these it derives a two-bit result each clock: whether an offset is applied, and if so whether it is the positive or the negative half of the tone amplitude.

The internal tone comes from a free-running divide-by-16 of the tick. When gating turns the internal tone on or off, the change waits until the end of the current tone period, so no shortened half-cycle reaches the output. The external pin passes through a synchroniser before use.

The source bit and the gate bit, together with the pin, give four usage schemes:
- internal tone gated by the bit;
- internal tone gated by the pin;
- external tone gated by the bit;
- raw external tone with the bit held on.

In the raw external scheme a pin that stops toggling leaves the output parked at plus or minus half amplitude, following the pin level.

Top module: `tone_gen_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tone_on_o` and `tone_pos_o` are 0. Both control bits reset-default to 0 at the register source.
- R2: The internal tone period is 16 ticks: 8 ticks positive (`tone_pos_o`=1) followed by 8 ticks negative, starting with the positive half at each period boundary.
- R3: With `src_int_i`=1 the output follows the internal divider. With `src_int_i`=0 it follows the synchronised pin.
- R4: With `src_int_i`=1 the internal tone is requested when `gate_i`=1 or the synchronised pin is 1. A change of request takes effect only at the tick that ends a tone period.
- R5: With `src_int_i`=0 and `gate_i`=1, `tone_on_o` is 1 one clock later, and `tone_pos_o` equals the pin level seen through two synchroniser flops and the output register (three clocks).
- R6: When no tone is applied the output is centred: `tone_on_o`=0 forces `tone_pos_o`=0. Encoding: on=1,pos=1 is +half; on=1,pos=0 is -half; on=0 is centre.
- R7: With `src_int_i`=0 and `gate_i`=1, a pin that stops toggling parks the output at +half (pin high) or -half (pin low) for as long as it stays still.
- R8: With `src_int_i`=0 and `gate_i`=0 the pin has no effect: the output stays centred whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse at 352 kHz |
| ext_mod_i | input | 1 | Asynchronous external modulation pin |
| src_int_i | input | 1 | Source select: 1 internal, 0 external pin |
| gate_i | input | 1 | Tone gate bit |
| tone_on_o | output | 1 | Offset applied (0 = centre level) |
| tone_pos_o | output | 1 | 1 = +half amplitude, 0 = -half |

## Verification
The bench goes after the period boundary. It raises and drops the gate in the middle of a period, and a design that gated at once would emit a truncated first or last half-cycle. Fixed high and low pin levels with the external source check the parked level: a design with the sign inverted or with the pin gated out would park at the wrong side or at centre. It also checks that a gated-off external source ignores pin activity, and that the pin alone can turn on the internal tone. Random phases of tick, pin and control bits are compared cycle by cycle against a bench model built from the requirements.

// File: rtl/tone_gen_pkg.sv
package tone_gen_pkg;
   typedef struct packed {
      logic on;
      logic pos;
   } tone_out_t;

   localparam tone_out_t TONE_CENTRE = '{on: 1'b0, pos: 1'b0};
endpackage

// File: rtl/tgc_sync.sv
module tgc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad
      $error("tgc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tgc_divider.sv
module tgc_divider #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic phase_pos_o,
   output logic wrap_o
);
   localparam int CW   = $clog2(DIV);
   localparam int HALF = DIV / 2;
   localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
   localparam logic [CW-1:0] HALFV = CW'(HALF);

   if (DIV < 2 || (DIV % 2) != 0) begin : g_bad
      $error("tgc_divider: DIV must be even and at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign wrap_o      = tick_i && (cnt_q == LAST);
   assign phase_pos_o = (cnt_q < HALFV);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (wrap_o) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end

   assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/tgc_gate.sv
module tgc_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap_i,
   input  logic req_i,
   output logic en_o
);
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      en_q <= 1'b0;
      else if (wrap_i) en_q <= req_i;
   end

   assign en_o = en_q;

   assert_gate_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_i |=> $stable(en_q));
endmodule

// File: rtl/tone_gen_ctrl.sv
module tone_gen_ctrl
   import tone_gen_pkg::*;
#(
   parameter int DIV         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic ext_mod_i,
   input  logic src_int_i,
   input  logic gate_i,
   output logic tone_on_o,
   output logic tone_pos_o
);
   logic      ext_s;
   logic      phase_pos;
   logic      wrap;
   logic      int_en;
   tone_out_t nxt;
   tone_out_t out_q;

   tgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ext_mod_i), .sync_o(ext_s));

   tgc_divider #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .phase_pos_o(phase_pos), .wrap_o(wrap));

   tgc_gate u_gate (
      .clk(clk), .rst_n(rst_n), .wrap_i(wrap),
      .req_i(gate_i | ext_s), .en_o(int_en));

   always_comb begin
      nxt = TONE_CENTRE;
      if (src_int_i) begin
         if (int_en) nxt = '{on: 1'b1, pos: phase_pos};
      end else if (gate_i) begin
         nxt = '{on: 1'b1, pos: ext_s};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_q <= TONE_CENTRE;
      else        out_q <= nxt;
   end

   assign tone_on_o  = out_q.on;
   assign tone_pos_o = out_q.pos;

   assert_centre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_on_o |-> !tone_pos_o);

   assert_ext_gated_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_int_i && gate_i) |=> tone_on_o);

   assert_ext_gated_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_int_i && !gate_i) |=> !tone_on_o);
endmodule

// File: tb/tone_gen_ctrl_tb.sv
module tone_gen_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_GAP   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic ext = 1'b0;
   logic src_int = 1'b0;
   logic gate = 1'b0;
   logic tone_on, tone_pos;

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit cmp_on = 0;
   bit tick_run = 0;
   int tick_div = 0;

   int m_cnt;
   logic m_en, m_s1, m_s2, m_on, m_pos;

   always #(CLK_PERIOD/2) clk = ~clk;

   tone_gen_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_mod_i(ext),
      .src_int_i(src_int), .gate_i(gate),
      .tone_on_o(tone_on), .tone_pos_o(tone_pos));

   function automatic logic exp_on(logic s, logic g, logic en);
      return s ? en : g;
   endfunction

   function automatic logic exp_pos(logic s, logic g, logic en, int c, logic ps);
      return s ? (en && c < 8) : (g && ps);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 0; m_en <= 0; m_s1 <= 0; m_s2 <= 0; m_on <= 0; m_pos <= 0;
      end else begin
         m_on  <= exp_on(src_int, gate, m_en);
         m_pos <= exp_pos(src_int, gate, m_en, m_cnt, m_s2);
         m_s1  <= ext;
         m_s2  <= m_s1;
         if (tick && m_cnt == 15) begin
            m_cnt <= 0;
            m_en  <= gate | m_s2;
         end else if (tick) m_cnt <= m_cnt + 1;
      end
   end

   always @(negedge clk) begin
      if (tick_run) begin
         tick_div = (tick_div + 1) % TICK_GAP;
         tick = (tick_div == 0);
      end else tick = 1'b0;
   end

   task automatic check(string req, logic act_on, logic act_pos, logic e_on, logic e_pos);
      total++;
      if (act_on !== e_on || act_pos !== e_pos) begin
         bad++;
         $display("FAIL %s: on/pos actual=%b%b expected=%b%b at %0t",
                  req, act_on, act_pos, e_on, e_pos, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) check("R3 model", tone_on, tone_pos, m_on, m_pos);
   end

   task automatic wait_clk(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed));
      wait_clk(3);
      check("R1 reset", tone_on, tone_pos, 1'b0, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      wait_clk(1);
      check("R1 first cycle", tone_on, tone_pos, 1'b0, 1'b0);
      tick_run = 1;
      cmp_on = 1;

      // R2/R4: internal tone with the gate bit, measure half periods
      src_int = 1; gate = 1;
      begin
         int hi = 0, lo = 0, t = 0;
         while (!(tone_on && tone_pos) && t < 200) begin wait_clk(1); t++; end
         while (tone_on && tone_pos && hi < 200) begin wait_clk(1); hi++; end
         while (tone_on && !tone_pos && lo < 200) begin wait_clk(1); lo++; end
         total++;
         if (hi != 8*TICK_GAP) begin bad++; $display("FAIL R2 high clocks: actual=%0d expected=%0d", hi, 8*TICK_GAP); end
         total++;
         if (lo != 8*TICK_GAP) begin bad++; $display("FAIL R2 low clocks: actual=%0d expected=%0d", lo, 8*TICK_GAP); end
      end

      // R4: gate dropped mid period, tone must finish the period
      wait_clk(5 * TICK_GAP);
      gate = 0;
      wait_clk(2);
      check("R4 gate off mid period holds", tone_on, 1'b0, 1'b1, 1'b0);
      wait_clk(40 * TICK_GAP);
      check("R4 gate off after boundary", tone_on, tone_pos, 1'b0, 1'b0);

      // R4: pin alone requests internal tone
      ext = 1;
      wait_clk(40 * TICK_GAP);
      check("R4 pin gates internal", tone_on, 1'b0, 1'b1, 1'b0);
      ext = 0;
      wait_clk(40 * TICK_GAP);
      check("R6 pin released centre", tone_on, tone_pos, 1'b0, 1'b0);

      // R7/R5: external source gated on, park high and low
      src_int = 0; gate = 1; ext = 1;
      wait_clk(6);
      check("R7 park high", tone_on, tone_pos, 1'b1, 1'b1);
      ext = 0;
      wait_clk(2);
      check("R5 sync latency not yet", tone_on, tone_pos, 1'b1, 1'b1);
      wait_clk(1);
      check("R5 sync latency reached", tone_on, tone_pos, 1'b1, 1'b0);
      wait_clk(6);
      check("R7 park low", tone_on, tone_pos, 1'b1, 1'b0);

      // R8: external source gated off ignores pin
      gate = 0;
      for (int i = 0; i < 12; i++) begin
         ext = i[1];
         wait_clk(1);
         if (i > 0) check("R8 pin ignored", tone_on, tone_pos, 1'b0, 1'b0);
      end

      // random phase, compared against model every cycle (R3)
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 99) < 20) ext = ~ext;
         if ($urandom_range(0, 299) == 0) src_int = ~src_int;
         if ($urandom_range(0, 199) == 0) gate = ~gate;
         wait_clk(1);
      end

      cmp_on = 0;
      finish_run();
   end
endmodule